// File: doc/BRIEF.md
# Dual-Compare Counter Clock Generator

This block derives a slow square clock from a fast system clock. A counter runs from zero up to a period reference and then wraps. It emits a single-cycle tick at zero, at a high-time reference and at the period reference. A one-bit phase register turns on at the zero tick and turns off at the high-time tick. The output is the OR of the phase bit and the zero tick, so a new high phase is visible in the same cycle the counter sits at zero. The high time and the period are therefore set independently of each other and are not limited to even divide ratios.

The generator runs only while its enable is held. Dropping the enable clears the counter and the phase bit, which forces the output low at once. The next enable therefore starts with a complete high phase. The two references are captured only while the block is disabled, so a running clock cannot be reshaped part-way through a period. A pair of references that cannot form a clock keeps the output parked low. A one-cycle strobe marks every rising edge of the generated clock, so that counters downstream can count edges without their own edge detector.

Top module: `dcclk_gen`

## Requirements
- R1: While reset is high, `gclk_o` and `rise_o` are 0.
- R2: With latched references H and P (1 <= H < P), each high phase of `gclk_o` lasts H+1 system clock cycles.
- R3: Consecutive rising edges of `gclk_o` are P+1 system clock cycles apart, and the internal count never exceeds P while running.
- R4: In the first cycle in which `run_en` is high with valid latched references, `gclk_o` is already high, and a full high phase of H+1 cycles follows.
- R5: In any cycle in which `run_en` is low, `gclk_o` is 0. After a disable, the next enable yields a full H+1 high phase, even if the previous high phase was cut short.
- R6: `hi_ref` and `per_ref` are sampled only on clock edges where `run_en` is low. A change to them while enabled has no effect on the running clock and takes effect after the next disable.
- R7: If the latched references have H = 0 or P <= H, `gclk_o` stays 0 and `rise_o` never pulses, even while enabled.
- R8: `rise_o` is high for exactly one cycle at each rising edge of `gclk_o`, including the first edge after enable, and it is never high while `gclk_o` is low.
- R9: With H = 49 and P = 99, the output is high for 50 cycles out of every 100, which is a 50 % duty cycle at 1/100 of the system clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Enables generation; low clears counter and phase |
| hi_ref | input | W | High-time reference H (high lasts H+1 cycles) |
| per_ref | input | W | Period reference P (period is P+1 cycles) |
| gclk_o | output | 1 | Generated clock |
| rise_o | output | 1 | One-cycle strobe at each rising edge of `gclk_o` |

## Verification
The bench programs several reference pairs: a narrow pair (1,2), a skewed pair (3,7), an almost-all-high pair (5,6) and the balanced pair (49,99). In each case it measures the length of the first high run and the distance between strobes, which separates a fault in the compare that ends the high phase from a fault in the compare that wraps the counter. Enable is also dropped in the middle of a high phase and asserted again, which shows whether the counter and phase really clear. The references are changed while the block runs and again after a disable, and three invalid pairs are tried, which shows whether the latch gating and the validity check work.

// File: rtl/dcclk_pkg.sv
package dcclk_pkg;

    localparam int DEF_W = 8;

    typedef struct packed {
        logic zero;
        logic hit_hi;
        logic hit_per;
    } tick_t;

    function automatic logic refs_ok(input logic [31:0] hi, input logic [31:0] per);
        return (hi != 32'd0) && (per > hi);
    endfunction

    function automatic logic next_phase(input logic cur, input logic zero, input logic hit_hi);
        return (cur & ~hit_hi) | (~cur & zero);
    endfunction

endpackage

// File: rtl/dcclk_refs.sv
module dcclk_refs
    import dcclk_pkg::*;
#(
    parameter int W = DEF_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run_en,
    input  logic [W-1:0] hi_in,
    input  logic [W-1:0] per_in,
    output logic [W-1:0] hi_q,
    output logic [W-1:0] per_q,
    output logic         cfg_ok
);

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q  <= '0;
            per_q <= '0;
        end else if (!run_en) begin
            hi_q  <= hi_in;
            per_q <= per_in;
        end
    end

    always_comb begin
        cfg_ok = refs_ok(32'(hi_q), 32'(per_q));
    end

endmodule

// File: rtl/dcclk_counter.sv
module dcclk_counter
    import dcclk_pkg::*;
#(
    parameter int W = DEF_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic [W-1:0] hi_q,
    input  logic [W-1:0] per_q,
    output logic [W-1:0] cnt,
    output tick_t        tick
);

    always_comb begin
        tick.zero    = run && (cnt == '0);
        tick.hit_hi  = run && (cnt == hi_q);
        tick.hit_per = run && (cnt == per_q);
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (tick.hit_per) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + W'(1);
        end
    end

endmodule

// File: rtl/dcclk_phase.sv
module dcclk_phase
    import dcclk_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic zero,
    input  logic hit_hi,
    output logic gclk,
    output logic rise
);

    logic phase_q;
    logic gclk_prev;

    always_comb begin
        gclk = run & (phase_q | zero);
        rise = gclk & ~gclk_prev;
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            phase_q   <= 1'b0;
            gclk_prev <= 1'b0;
        end else begin
            phase_q   <= next_phase(phase_q, zero, hit_hi);
            gclk_prev <= gclk;
        end
    end

endmodule

// File: rtl/dcclk_gen.sv
module dcclk_gen
    import dcclk_pkg::*;
#(
    parameter int W = DEF_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run_en,
    input  logic [W-1:0] hi_ref,
    input  logic [W-1:0] per_ref,
    output logic         gclk_o,
    output logic         rise_o
);

    logic [W-1:0] hi_lat;
    logic [W-1:0] per_lat;
    logic         cfg_ok;
    logic         run;
    logic [W-1:0] cnt;
    tick_t        tick;

    dcclk_refs #(.W(W)) u_refs (
        .clk    (clk),
        .rst    (rst),
        .run_en (run_en),
        .hi_in  (hi_ref),
        .per_in (per_ref),
        .hi_q   (hi_lat),
        .per_q  (per_lat),
        .cfg_ok (cfg_ok)
    );

    always_comb begin
        run = run_en & cfg_ok & ~rst;
    end

    dcclk_counter #(.W(W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .run   (run),
        .hi_q  (hi_lat),
        .per_q (per_lat),
        .cnt   (cnt),
        .tick  (tick)
    );

    dcclk_phase u_phase (
        .clk    (clk),
        .rst    (rst),
        .run    (run),
        .zero   (tick.zero),
        .hit_hi (tick.hit_hi),
        .gclk   (gclk_o),
        .rise   (rise_o)
    );

endmodule

// File: rtl/dcclk_gen_chk.sv
module dcclk_gen_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         run_en,
    input logic [W-1:0] hi_lat,
    input logic [W-1:0] per_lat,
    input logic [W-1:0] cnt,
    input logic         gclk_o,
    input logic         rise_o
);

    logic lat_ok;
    always_comb begin
        lat_ok = (hi_lat != '0) && (per_lat > hi_lat);
    end

    always_comb begin
        if (rst) begin
            p_rst_quiet_r1: assert (!gclk_o && !rise_o)
                else $error("R1: output active during reset");
        end
    end

    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
        (run_en && lat_ok) |-> (cnt <= per_lat))
        else $error("R3: count above period reference");

    p_start_high_r4: assert property (@(posedge clk) disable iff (rst)
        ($rose(run_en) && lat_ok) |-> gclk_o)
        else $error("R4: clock not high at enable");

    p_dis_low_r5: assert property (@(posedge clk) disable iff (rst)
        !run_en |-> !gclk_o)
        else $error("R5: clock high while disabled");

    p_ref_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (run_en && $past(run_en)) |-> ($stable(hi_lat) && $stable(per_lat)))
        else $error("R6: references changed while enabled");

    p_invalid_low_r7: assert property (@(posedge clk) disable iff (rst)
        !lat_ok |-> (!gclk_o && !rise_o))
        else $error("R7: clock active with invalid references");

    p_rise_in_high_r8: assert property (@(posedge clk) disable iff (rst)
        rise_o |-> gclk_o)
        else $error("R8: strobe while clock low");

    p_rise_single_r8: assert property (@(posedge clk) disable iff (rst)
        rise_o |=> !rise_o)
        else $error("R8: strobe longer than one cycle");

endmodule

bind dcclk_gen dcclk_gen_chk #(.W(W)) i_chk (
    .clk     (clk),
    .rst     (rst),
    .run_en  (run_en),
    .hi_lat  (hi_lat),
    .per_lat (per_lat),
    .cnt     (cnt),
    .gclk_o  (gclk_o),
    .rise_o  (rise_o)
);

// File: tb/test_dcclk_gen.sv
`timescale 1ns/1ps
module test_dcclk_gen;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         run_en = 1'b0;
    logic [W-1:0] hi_ref = '0;
    logic [W-1:0] per_ref = '0;
    logic         gclk_o;
    logic         rise_o;

    int total = 0;
    int fails = 0;

    always #10 clk = ~clk;

    dcclk_gen #(.W(W)) i_dcclk_gen (
        .clk     (clk),
        .rst     (rst),
        .run_en  (run_en),
        .hi_ref  (hi_ref),
        .per_ref (per_ref),
        .gclk_o  (gclk_o),
        .rise_o  (rise_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic program_refs(input int hi, input int per);
        run_en  = 1'b0;
        hi_ref  = W'(hi);
        per_ref = W'(per);
        step(2);
        run_en = 1'b1;
        #1;
    endtask

    task automatic measure(input int win, output int hi_len, output int per_len,
                           output int nstb, output int bad);
        int first;
        int second;
        bit in_first;
        first = -1; second = -1; in_first = 1'b1;
        hi_len = 0; nstb = 0; bad = 0;
        for (int i = 0; i < win; i++) begin
            if (in_first && gclk_o) hi_len++;
            else in_first = 1'b0;
            if (rise_o) begin
                nstb++;
                if (first < 0) first = i;
                else if (second < 0) second = i;
                if (!gclk_o) bad++;
            end
            step(1);
        end
        per_len = (second >= 0) ? second - first : -1;
    endtask

    task automatic t_reset();
        run_en = 1'b1;
        #1;
        chk("R1 gclk in reset", int'(gclk_o), 0);
        chk("R1 rise in reset", int'(rise_o), 0);
        step(2);
        rst = 1'b0;
        run_en = 1'b0;
        step(1);
    endtask

    task automatic t_shape(input int hi, input int per, input string tag);
        int hl, pl, ns, bd;
        program_refs(hi, per);
        chk({tag, " R4 high at enable"}, int'(gclk_o), 1);
        chk({tag, " R8 strobe at enable"}, int'(rise_o), 1);
        measure(2 * per + 3, hl, pl, ns, bd);
        chk({tag, " R2 high length"}, hl, hi + 1);
        chk({tag, " R3 period"}, pl, per + 1);
        chk({tag, " R8 strobe count"}, ns, 3);
        chk({tag, " R8 strobe while low"}, bd, 0);
        run_en = 1'b0;
        step(1);
    endtask

    task automatic t_disable();
        int hl, pl, ns, bd;
        program_refs(4, 9);
        step(2);
        chk("R5 still high mid phase", int'(gclk_o), 1);
        run_en = 1'b0;
        #1;
        chk("R5 low at disable", int'(gclk_o), 0);
        step(3);
        chk("R5 low while disabled", int'(gclk_o), 0);
        run_en = 1'b1;
        #1;
        measure(12, hl, pl, ns, bd);
        chk("R5 full high after re-enable", hl, 5);
        chk("R5 period after re-enable", pl, 10);
        run_en = 1'b0;
        step(1);
    endtask

    task automatic t_ref_hold();
        int hl, pl, ns, bd;
        program_refs(3, 7);
        step(2);
        hi_ref  = W'(1);
        per_ref = W'(3);
        measure(19, hl, pl, ns, bd);
        chk("R6 period kept while enabled", pl, 8);
        run_en = 1'b0;
        step(2);
        run_en = 1'b1;
        #1;
        measure(11, hl, pl, ns, bd);
        chk("R6 new high after disable", hl, 2);
        chk("R6 new period after disable", pl, 4);
        run_en = 1'b0;
        step(1);
    endtask

    task automatic t_invalid(input int hi, input int per, input string tag);
        int highs;
        int stbs;
        highs = 0; stbs = 0;
        program_refs(hi, per);
        for (int i = 0; i < 20; i++) begin
            if (gclk_o) highs++;
            if (rise_o) stbs++;
            step(1);
        end
        chk({tag, " R7 no high"}, highs, 0);
        chk({tag, " R7 no strobe"}, stbs, 0);
        run_en = 1'b0;
        step(1);
    endtask

    initial begin
        #2_000_000;
        fails++;
        total++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_shape(3, 7, "pair3_7");
        t_shape(1, 2, "pair1_2");
        t_shape(5, 6, "pair5_6");
        t_shape(49, 99, "R9 pair49_99");
        t_disable();
        t_ref_hold();
        t_invalid(0, 5, "hi_zero");
        t_invalid(5, 5, "equal");
        t_invalid(6, 3, "reversed");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule